// File: doc/BRIEF.md
# Interrupt Acknowledge Target

This block is a bus target that answers only one kind of transaction: the interrupt acknowledge command. At each bus clock it watches the cycle frame, the command and byte-enable lines, the address/data bus, the initiator ready line and the parity line. When a new transaction starts with the interrupt acknowledge command code, the block claims the transaction. It does not decode an address, because the address-phase contents mean nothing for this command. It then asks a local interrupt source for a vector over a simple request/valid handshake. Once the vector arrives, the block signals target ready and drives the vector onto the data bus. Only the bytes that the initiator enables in the data phase carry the vector.

All bus signals that the block can drive come out as a value plus an output enable, so the tri-state buffers stay in the pad ring. The block handles a single data phase. The claim delay parameter sets the decode speed (1 = fast, 2 = medium, 3 = slow) and defaults to medium.

Top module: `irq_ack_target`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, every output enable (`devselOe_o`, `trdyOe_o`, `adOe_o`, `parOe_o`), `vecReq_o` and `addrParErr_o` are 0, and `ad_o` is all zeros.
- R2: An address phase is a clock edge where `frameN_i` is sampled low and the bus was idle (`frameN_i` and `irdyN_i` both high) at the previous edge. The block claims a transaction only if `cbeN_i` equals 4'b0000 at that edge. Any other command leaves every output enable and `vecReq_o` at 0, and the value on `ad_i` in the address phase has no effect.
- R3: For a claimed transaction, `devselOe_o` = 1 and `devselN_o` = 0 take effect just after the CLAIM_DELAY-th rising edge following the address edge (the second edge by default). Neither is driven before that.
- R4: From the claim, `trdyOe_o` = 1 with `trdyN_o` = 1, and `vecReq_o` stays high until an edge samples `vecValid_i` high. That edge captures `vecData_i`, drops `vecReq_o`, and makes `trdyN_o` 0 right after it.
- R5: While `trdyN_o` is 0, `adOe_o` = 1. Byte b of `ad_o` (bits 8b+7..8b) equals byte b of the captured vector when `cbeN_i[b]` is 0, and is zero otherwise. TRDY and the data hold until the first edge that samples `irdyN_i` low, which is the transfer edge.
- R6: In the cycle after each cycle in which the block drives data, `parOe_o` = 1 and `par_o` makes the count of ones across the previous cycle's `ad_o`, `cbeN_i` and `par_o` even.
- R7: In the cycle after the transfer edge, DEVSEL and TRDY are driven high (enables 1, values 1) and `adOe_o` is 0. In the cycle after that, `devselOe_o` and `trdyOe_o` are 0.
- R8: For a claimed transaction, `par_i` is sampled at the edge after the address edge. If `par_i` does not give even parity over the address-phase `ad_i` and `cbeN_i`, `addrParErr_o` is high for exactly the one cycle after that edge. Transactions that are not claimed never raise it.
- R9: The block claims at most once per transaction, and `trdyN_o` is never driven low unless DEVSEL is driven low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| frameN_i | input | 1 | Cycle frame, active low |
| irdyN_i | input | 1 | Initiator ready, active low |
| cbeN_i | input | BE_W | Command (address phase) / byte enables (data phase), active low |
| ad_i | input | AD_W | Address/data bus as received |
| par_i | input | 1 | Parity line as received |
| devselN_o | output | 1 | Device select value |
| devselOe_o | output | 1 | Device select output enable |
| trdyN_o | output | 1 | Target ready value |
| trdyOe_o | output | 1 | Target ready output enable |
| ad_o | output | AD_W | Vector data to drive onto the bus |
| adOe_o | output | 1 | Address/data output enable |
| par_o | output | 1 | Data-phase parity value |
| parOe_o | output | 1 | Parity output enable |
| addrParErr_o | output | 1 | One-cycle address parity error pulse |
| vecReq_o | output | 1 | Vector request to the local interrupt source |
| vecValid_i | input | 1 | Vector valid from the local interrupt source |
| vecData_i | input | AD_W | Interrupt vector from the local source |

## Verification
The assertions check on every cycle the protocol relations that hold at all times:
- the claim lands exactly CLAIM_DELAY edges after an address phase and only for the acknowledge command;
- TRDY never goes low without DEVSEL, and only after the handshake completes;
- the driven-high turnaround cycle precedes release;
- `par_o` gives even parity over the data driven one cycle earlier;
- disabled bytes read zero;
- the parity error pulse lasts one cycle.

Only the bench scenarios can show the end-to-end values: the captured vector under each byte-enable pattern, data held across initiator wait states, the correct error verdict for good and bad address parity, and silence for every other command.

// File: rtl/irqack_pkg.sv
package irqack_pkg;

  // Command code on the C/BE lines that selects this target.
  localparam logic [3:0] CMD_INT_ACK = 4'b0000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_CLAIM,
    ST_DATA,
    ST_TURN
  } ackState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic captureAddr;  // address phase of an acknowledge cycle
    logic loadVec;      // vector handshake completes this edge
    logic driveData;    // data phase: AD driven with the vector
  } dpStrobe_t;

endpackage

// File: rtl/irqack_datapath.sv
module irqack_datapath
  import irqack_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbeN_i,
  input  logic            par_i,
  input  logic [AD_W-1:0] vecData_i,
  output logic            cmdIsIntAck,
  output logic [AD_W-1:0] ad_o,
  output logic            par_o,
  output logic            addrParErr_o
);

  logic [AD_W-1:0] vecReg;
  logic [AD_W-1:0] byteMask;
  logic [AD_W-1:0] adDrive;
  logic            addrParity;
  logic            parPending;
  logic            parErrReg;
  logic            parReg;

  // Command decode: the address itself plays no part in selection.
  assign cmdIsIntAck = (cbeN_i == BE_W'(CMD_INT_ACK));

  // Byte lanes enabled by the active-low byte enables.
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign byteMask[b*8 +: 8] = {8{~cbeN_i[b]}};
  end

  assign adDrive = vecReg & byteMask;
  assign ad_o    = strobe.driveData ? adDrive : '0;

  // Address-phase parity: the address bits are latched only for the
  // parity check, one clock before PAR arrives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrParity <= 1'b0;
      parPending <= 1'b0;
      parErrReg  <= 1'b0;
    end else begin
      parPending <= strobe.captureAddr;
      if (strobe.captureAddr) begin
        addrParity <= ^{ad_i, cbeN_i};
      end
      parErrReg <= parPending & (addrParity ^ par_i);
    end
  end

  assign addrParErr_o = parErrReg;

  // Vector capture from the local interrupt source.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg <= '0;
    end else if (strobe.loadVec) begin
      vecReg <= vecData_i;
    end
  end

  // Data-phase parity, presented one clock after the data it covers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parReg <= 1'b0;
    end else if (strobe.driveData) begin
      parReg <= ^{adDrive, cbeN_i};
    end
  end

  assign par_o = parReg;

endmodule

// File: rtl/irqack_ctrl.sv
module irqack_ctrl
  import irqack_pkg::*;
#(
  parameter int CLAIM_DELAY = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameN_i,
  input  logic      irdyN_i,
  input  logic      cmdIsIntAck,
  input  logic      vecValid_i,
  output dpStrobe_t strobe,
  output logic      devselN_o,
  output logic      devselOe_o,
  output logic      trdyN_o,
  output logic      trdyOe_o,
  output logic      adOe_o,
  output logic      parOe_o,
  output logic      vecReq_o
);

  localparam int CNT_W = $clog2(CLAIM_DELAY + 1);

  ackState_t  state, stateNext;
  logic [CNT_W-1:0] delayCnt;
  logic       busIdlePrev;
  logic       addrPhase;
  logic       parOeReg;

  // A new transaction starts when FRAME is sampled low after an idle bus.
  assign addrPhase = busIdlePrev & ~frameN_i;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busIdlePrev <= 1'b1;
    end else begin
      busIdlePrev <= frameN_i & irdyN_i;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (addrPhase && cmdIsIntAck) stateNext = ST_DECODE;
      ST_DECODE: if (delayCnt == '0) stateNext = ST_CLAIM;
      ST_CLAIM:  if (vecValid_i) stateNext = ST_DATA;
      ST_DATA:   if (!irdyN_i) stateNext = ST_TURN;
      ST_TURN:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      delayCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE) begin
        delayCnt <= CNT_W'(CLAIM_DELAY - 1);
      end else if (state == ST_DECODE && delayCnt != '0) begin
        delayCnt <= delayCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parOeReg <= 1'b0;
    end else begin
      parOeReg <= (state == ST_DATA);
    end
  end

  assign strobe.captureAddr = (state == ST_IDLE) & addrPhase & cmdIsIntAck;
  assign strobe.loadVec     = (state == ST_CLAIM) & vecValid_i;
  assign strobe.driveData   = (state == ST_DATA);

  assign devselOe_o = (state == ST_CLAIM) | (state == ST_DATA) | (state == ST_TURN);
  assign trdyOe_o   = devselOe_o;
  assign devselN_o  = ~((state == ST_CLAIM) | (state == ST_DATA));
  assign trdyN_o    = ~(state == ST_DATA);
  assign adOe_o     = (state == ST_DATA);
  assign parOe_o    = parOeReg;
  assign vecReq_o   = (state == ST_CLAIM);

endmodule

// File: rtl/irq_ack_target.sv
module irq_ack_target
  import irqack_pkg::*;
#(
  parameter int AD_W        = 32,
  parameter int CLAIM_DELAY = 2,
  localparam int BE_W       = AD_W / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameN_i,
  input  logic            irdyN_i,
  input  logic [BE_W-1:0] cbeN_i,
  input  logic [AD_W-1:0] ad_i,
  input  logic            par_i,
  output logic            devselN_o,
  output logic            devselOe_o,
  output logic            trdyN_o,
  output logic            trdyOe_o,
  output logic [AD_W-1:0] ad_o,
  output logic            adOe_o,
  output logic            par_o,
  output logic            parOe_o,
  output logic            addrParErr_o,
  output logic            vecReq_o,
  input  logic            vecValid_i,
  input  logic [AD_W-1:0] vecData_i
);

  dpStrobe_t strobe;
  logic      cmdIsIntAck;

  irqack_ctrl #(
    .CLAIM_DELAY(CLAIM_DELAY)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameN_i   (frameN_i),
    .irdyN_i    (irdyN_i),
    .cmdIsIntAck(cmdIsIntAck),
    .vecValid_i (vecValid_i),
    .strobe     (strobe),
    .devselN_o  (devselN_o),
    .devselOe_o (devselOe_o),
    .trdyN_o    (trdyN_o),
    .trdyOe_o   (trdyOe_o),
    .adOe_o     (adOe_o),
    .parOe_o    (parOe_o),
    .vecReq_o   (vecReq_o)
  );

  irqack_datapath #(
    .AD_W(AD_W),
    .BE_W(BE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ad_i        (ad_i),
    .cbeN_i      (cbeN_i),
    .par_i       (par_i),
    .vecData_i   (vecData_i),
    .cmdIsIntAck (cmdIsIntAck),
    .ad_o        (ad_o),
    .par_o       (par_o),
    .addrParErr_o(addrParErr_o)
  );

endmodule

// File: rtl/irqack_checker.sv
module irqack_checker #(
  parameter int AD_W        = 32,
  parameter int CLAIM_DELAY = 2,
  localparam int BE_W       = AD_W / 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            frameN_i,
  input logic            irdyN_i,
  input logic [BE_W-1:0] cbeN_i,
  input logic            vecValid_i,
  input logic            vecReq_o,
  input logic            devselN_o,
  input logic            devselOe_o,
  input logic            trdyN_o,
  input logic            trdyOe_o,
  input logic [AD_W-1:0] ad_o,
  input logic            adOe_o,
  input logic            par_o,
  input logic            parOe_o,
  input logic            addrParErr_o
);

  logic       idlePrev;
  logic       lastWasAck;
  logic [7:0] sinceAddr;
  logic       claimed;

  assign claimed = devselOe_o & ~devselN_o;

  // Bus monitor: edges since the most recent address phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idlePrev   <= 1'b1;
      lastWasAck <= 1'b0;
      sinceAddr  <= '0;
    end else begin
      idlePrev <= frameN_i & irdyN_i;
      if (idlePrev && !frameN_i) begin
        lastWasAck <= (cbeN_i == '0);
        sinceAddr  <= '0;
      end else if (sinceAddr != 8'hFF) begin
        sinceAddr <= sinceAddr + 8'd1;
      end
    end
  end

  AST_CLAIM_ONLY_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(claimed) |-> lastWasAck); // R2

  AST_CLAIM_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(claimed) |-> (sinceAddr == 8'(CLAIM_DELAY))); // R3

  AST_REQ_WHILE_CLAIMED: assert property (@(posedge clk) disable iff (!rstN)
    vecReq_o |-> (claimed && trdyOe_o && trdyN_o)); // R4

  AST_TRDY_AFTER_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trdyN_o) |-> $past(vecReq_o && vecValid_i)); // R4

  AST_DATA_WITH_TRDY: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe_o && !trdyN_o) |-> adOe_o); // R5

  for (genvar b = 0; b < BE_W; b++) begin : g_laneChk
    AST_UNUSED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      cbeN_i[b] |-> (ad_o[b*8 +: 8] == 8'h00)); // R5
  end

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    parOe_o |-> ((^{$past(ad_o), $past(cbeN_i), par_o}) == 1'b0)); // R6

  AST_TURN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe_o && !trdyN_o && !irdyN_i) |=>
      (devselOe_o && devselN_o && trdyOe_o && trdyN_o && !adOe_o)); // R7

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (devselOe_o && devselN_o && trdyOe_o && trdyN_o) |=>
      (!devselOe_o && !trdyOe_o)); // R7

  AST_PARERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    addrParErr_o |=> !addrParErr_o); // R8

  AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe_o && !trdyN_o) |-> claimed); // R9

  AST_SINGLE_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    $fell(claimed) |=> !claimed); // R9

endmodule

bind irq_ack_target irqack_checker #(
  .AD_W(AD_W),
  .CLAIM_DELAY(CLAIM_DELAY)
) u_irqack_checker (
  .clk         (clk),
  .rstN        (rstN),
  .frameN_i    (frameN_i),
  .irdyN_i     (irdyN_i),
  .cbeN_i      (cbeN_i),
  .vecValid_i  (vecValid_i),
  .vecReq_o    (vecReq_o),
  .devselN_o   (devselN_o),
  .devselOe_o  (devselOe_o),
  .trdyN_o     (trdyN_o),
  .trdyOe_o    (trdyOe_o),
  .ad_o        (ad_o),
  .adOe_o      (adOe_o),
  .par_o       (par_o),
  .parOe_o     (parOe_o),
  .addrParErr_o(addrParErr_o)
);

// File: tb/test_irq_ack_target.sv
module test_irq_ack_target;

  localparam int AD_W = 32;
  localparam int BE_W = AD_W / 8;
  localparam int CLAIM_DELAY = 2;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameN_i = 1'b1;
  logic            irdyN_i = 1'b1;
  logic [BE_W-1:0] cbeN_i = '1;
  logic [AD_W-1:0] ad_i = '0;
  logic            par_i = 1'b0;
  logic            vecValid_i = 1'b0;
  logic [AD_W-1:0] vecData_i = '0;
  logic            devselN_o, devselOe_o, trdyN_o, trdyOe_o;
  logic [AD_W-1:0] ad_o;
  logic            adOe_o, par_o, parOe_o, addrParErr_o, vecReq_o;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  irq_ack_target #(.AD_W(AD_W), .CLAIM_DELAY(CLAIM_DELAY)) i_irq_ack_target (
    .clk(clk), .rstN(rstN), .frameN_i(frameN_i), .irdyN_i(irdyN_i),
    .cbeN_i(cbeN_i), .ad_i(ad_i), .par_i(par_i),
    .devselN_o(devselN_o), .devselOe_o(devselOe_o),
    .trdyN_o(trdyN_o), .trdyOe_o(trdyOe_o),
    .ad_o(ad_o), .adOe_o(adOe_o), .par_o(par_o), .parOe_o(parOe_o),
    .addrParErr_o(addrParErr_o), .vecReq_o(vecReq_o),
    .vecValid_i(vecValid_i), .vecData_i(vecData_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [AD_W-1:0] expLanes(input logic [AD_W-1:0] v,
                                               input logic [BE_W-1:0] be);
    logic [AD_W-1:0] r = '0;
    for (int b = 0; b < BE_W; b++)
      if (!be[b]) r[b*8 +: 8] = v[b*8 +: 8];
    return r;
  endfunction

  function automatic logic evenPar(input logic [AD_W-1:0] a, input logic [BE_W-1:0] c);
    return ^{a, c};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // One acknowledge transaction, all checks made before new drives.
  task automatic runAck(input logic [AD_W-1:0] addr, input logic [BE_W-1:0] be,
                        input logic [AD_W-1:0] vec, input int vecLat,
                        input int irdyWait, input bit badPar);
    logic [AD_W-1:0] expAd;
    logic            aPar;
    aPar = evenPar(addr, '0) ^ badPar;
    expAd = expLanes(vec, be);
    frameN_i = 1'b0; cbeN_i = '0; ad_i = addr;
    tick(); // address edge passed
    check(!devselOe_o, "R3", "devsel enable before claim", 64'(devselOe_o), 0);
    cbeN_i = be; ad_i = $urandom; par_i = aPar; irdyN_i = 1'b1;
    tick(); // parity edge passed
    check(addrParErr_o == badPar, "R8", "address parity verdict", 64'(addrParErr_o), 64'(badPar));
    check(!devselOe_o, "R3", "devsel enable one edge after address", 64'(devselOe_o), 0);
    par_i = $urandom;
    tick(); // claim edge passed
    check(devselOe_o && !devselN_o, "R3", "devsel claim",
          64'({devselOe_o, devselN_o}), 64'b10);
    check(trdyOe_o && trdyN_o && vecReq_o, "R4", "trdy high while requesting",
          64'({trdyOe_o, trdyN_o, vecReq_o}), 64'b111);
    check(!addrParErr_o, "R8", "parity error lasts one cycle", 64'(addrParErr_o), 0);
    for (int i = 0; i < vecLat; i++) begin
      tick();
      check(trdyN_o && vecReq_o, "R4", "trdy waits for vector",
            64'({trdyN_o, vecReq_o}), 64'b11);
    end
    vecValid_i = 1'b1; vecData_i = vec;
    tick(); // vector edge passed
    check(!trdyN_o && !vecReq_o, "R4", "trdy after vector",
          64'({trdyN_o, vecReq_o}), 64'b00);
    check(adOe_o && ad_o == expAd, "R5", "vector lanes", 64'(ad_o), 64'(expAd));
    vecValid_i = 1'b0; vecData_i = $urandom;
    for (int i = 0; i < irdyWait; i++) begin
      tick();
      check(!trdyN_o && ad_o == expAd, "R5", "data held during initiator wait",
            64'(ad_o), 64'(expAd));
    end
    frameN_i = 1'b1; irdyN_i = 1'b0;
    tick(); // transfer edge passed
    check(devselOe_o && devselN_o && trdyOe_o && trdyN_o && !adOe_o, "R7",
          "turnaround driven high",
          64'({devselOe_o, devselN_o, trdyOe_o, trdyN_o, adOe_o}), 64'b11110);
    check(parOe_o && par_o == evenPar(expAd, be), "R6", "data parity",
          64'({parOe_o, par_o}), 64'({1'b1, evenPar(expAd, be)}));
    irdyN_i = 1'b1; cbeN_i = '1;
    tick();
    check(!devselOe_o && !trdyOe_o && !parOe_o, "R7", "release",
          64'({devselOe_o, trdyOe_o, parOe_o}), 0);
    tick();
  endtask

  // Transaction with another command: nothing may respond.
  task automatic runOther(input logic [BE_W-1:0] cmd);
    bit quiet = 1'b1;
    frameN_i = 1'b0; cbeN_i = cmd; ad_i = $urandom;
    vecValid_i = 1'b1; vecData_i = $urandom;
    tick();
    cbeN_i = 4'($urandom); par_i = ~evenPar(ad_i, cmd);
    frameN_i = 1'b1; irdyN_i = 1'b0;
    for (int i = 0; i < CLAIM_DELAY + 4; i++) begin
      tick();
      if (devselOe_o || trdyOe_o || adOe_o || vecReq_o || addrParErr_o) quiet = 1'b0;
      if (i == 3) irdyN_i = 1'b1;
    end
    check(quiet, "R2", "other command stays silent (R8 no error)", 64'(quiet), 1);
    vecValid_i = 1'b0; cbeN_i = '1;
    tick();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) tick();
    check(!devselOe_o && !trdyOe_o && !adOe_o && !parOe_o && !vecReq_o && !addrParErr_o,
          "R1", "outputs in reset", 64'({devselOe_o, trdyOe_o, adOe_o, parOe_o}), 0);
    rstN = 1'b1;
    tick();
    check(!devselOe_o && !vecReq_o && ad_o == '0, "R1", "outputs after reset",
          64'(ad_o), 0);
    // Directed corner cases
    runAck(32'hDEAD_BEEF, 4'b1110, 32'h1234_56A5, 0, 0, 1'b0); // single-byte vector
    runAck(32'h0000_0000, 4'b0000, 32'hCAFE_F00D, 5, 2, 1'b0); // full word, waits
    runAck(32'hFFFF_FFFF, 4'b1111, 32'h8765_4321, 1, 0, 1'b1); // no lanes, bad parity
    runAck(32'h0F0F_0F0F, 4'b0101, 32'hA1B2_C3D4, 2, 3, 1'b1);
    runOther(4'b0110);
    runOther(4'b0001);
    runAck(32'h1357_9BDF, 4'b1110, 32'h0000_0021, 0, 1, 1'b0); // R9 no repeat claim
    // Constrained random mix
    for (int n = 0; n < 40; n++) begin
      if (($urandom % 4) == 0) begin
        logic [BE_W-1:0] cmd;
        cmd = 4'($urandom % 15) + 4'd1;
        runOther(cmd);
      end else begin
        runAck($urandom, 4'($urandom), $urandom, int'($urandom % 4),
               int'($urandom % 3), 1'($urandom % 2));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule